// File: doc/BRIEF.md
# Narrow-Pin 32-bit Integer ALU

This block is a combinational integer arithmetic/logic unit with 32-bit RV32I semantics, fitted onto a small pin budget. One 8-bit input bus carries two 4-bit unsigned operands, one in each nibble. Inside the block each operand is zero-extended to 32 bits. A 4-bit operation code is taken from the low half of a second 8-bit input bus. The low byte of the 32-bit result drives an 8-bit output bus.

There is no clock, no register and no handshake. The result settles in the same cycle as the inputs that produce it. The datapath covers add, subtract, the three bitwise operations, signed and unsigned compare-less-than, and three shifts (logical left, logical right, arithmetic right). The shifts use a cascade of conditional stages, one stage for each bit of the shift amount. The bidirectional pin group is used only as inputs, so its output-enable bus and output bus are both tied to zero.

Top module: `nalu_top`

## Requirements
- R1: `result_o` depends only on the present values of `opnd_pack_i` and `sel_bus_i`. A change on either input shows on the output in the same cycle, without any clock edge.
- R2: Operand X is `opnd_pack_i[7:4]` and operand Y is `opnd_pack_i[3:0]`. Both are unsigned and zero-extended to 32 bits before any operation. `result_o` is bits [7:0] of the 32-bit result.
- R3: The operation code is `sel_bus_i[3:0]`. The bits `sel_bus_i[7:4]` have no effect on `result_o`.
- R4: Code 0x4 gives X+Y.
- R5: Code 0x6 gives X−Y modulo 2^32. For example, X=3 and Y=5 give 0xFE.
- R6: Code 0x7 gives X AND Y, code 0x8 gives X OR Y, and code 0x9 gives X XOR Y.
- R7: Code 0xA is a signed 32-bit compare and code 0xB is an unsigned one. Each gives 1 when X<Y and 0 otherwise.
- R8: Code 0x0 shifts X left by Y[4:0] and fills with zeros.
- R9: Code 0x1 shifts X right by Y[4:0] and fills with zeros. Code 0x2 shifts right and fills with bit 31 of X, which is always zero here, so it gives the same result as code 0x1.
- R10: Codes 0x3, 0x5 and 0xC through 0xF give a result of zero.
- R11: `aux_oe_o` and `aux_out_o` are zero at all times.
- R12: These fixed cases hold (packed operands, code, result):
  - 0x53, 0x4, 0x08
  - 0xA3, 0x6, 0x07
  - 0xF5, 0x7, 0x05
  - 0xA5, 0x8, 0x0F
  - 0xFF, 0x9, 0x00
  - 0x35, 0xA, 0x01

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_pack_i | input | 8 | Packed operands: X in [7:4], Y in [3:0] |
| sel_bus_i | input | 8 | Operation code in [3:0]; [7:4] unused |
| result_o | output | 8 | Low byte of the 32-bit result |
| aux_out_o | output | 8 | Bidirectional-group output data, tied to zero |
| aux_oe_o | output | 8 | Bidirectional-group output enables, held low |

## Verification
Every one of the 16 codes is applied with all 256 operand pairs. This exposes carries and wraps across the nibble boundary, every shift distance from 0 to 15, and every ordering of X against Y for the compares. The upper select nibble is varied from pair to pair, so a design that decoded more than four bits would diverge at some point. The fixed cases, including the 3−5 wrap, separate a zero-extended datapath from a sign-extended or 8-bit one. A separate same-cycle step confirms that the output follows the inputs with no clock edge in between.

// File: rtl/nalu_pkg.sv
package nalu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);
  localparam int unsigned CODE_W  = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_SLL  = 4'h0,
    OP_SRL  = 4'h1,
    OP_SRA  = 4'h2,
    OP_ADD  = 4'h4,
    OP_SUB  = 4'h6,
    OP_AND  = 4'h7,
    OP_OR   = 4'h8,
    OP_XOR  = 4'h9,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;
endpackage

// File: rtl/nalu_shifter.sv
module nalu_shifter #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [DW-1:0] res_o
);
  logic [SW:0][DW-1:0] lft_stage;
  logic [SW:0][DW-1:0] rgt_stage;
  logic                fill_bit;

  assign fill_bit     = arith_i & data_i[DW-1];
  assign lft_stage[0] = data_i;
  assign rgt_stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    logic [DW-1:0] fill_mask;
    assign fill_mask = fill_bit ? ~({DW{1'b1}} >> STEP) : '0;
    assign lft_stage[k+1] = amt_i[k] ? (lft_stage[k] << STEP) : lft_stage[k];
    assign rgt_stage[k+1] = amt_i[k] ? ((rgt_stage[k] >> STEP) | fill_mask)
                                     : rgt_stage[k];
  end

  assign res_o = left_i ? lft_stage[SW] : rgt_stage[SW];
endmodule

// File: rtl/nalu_addsub.sv
module nalu_addsub #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o
);
  logic [DW-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DW-1){1'b0}}, sub_i};
endmodule

// File: rtl/nalu_compare.sv
module nalu_compare #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          lt_s_o,
  output logic          lt_u_o
);
  logic sign_differs;
  assign lt_u_o       = a_i < b_i;
  assign sign_differs = a_i[DW-1] ^ b_i[DW-1];
  // With opposite signs the negative one is smaller; otherwise unsigned order holds.
  assign lt_s_o       = sign_differs ? a_i[DW-1] : lt_u_o;
endmodule

// File: rtl/nalu_top.sv
module nalu_top #(
  parameter int unsigned PIN_W = 8,
  parameter int unsigned NIB_W = 4
) (
  input  logic [PIN_W-1:0] opnd_pack_i,
  input  logic [PIN_W-1:0] sel_bus_i,
  output logic [PIN_W-1:0] result_o,
  output logic [PIN_W-1:0] aux_out_o,
  output logic [PIN_W-1:0] aux_oe_o
);
  import nalu_pkg::*;
  localparam int unsigned DW = DATA_W;
  localparam int unsigned SW = SHAMT_W;

  logic [DW-1:0]     opx, opy, sum, shifted, full_res;
  logic [CODE_W-1:0] code;
  logic              lt_s, lt_u, do_sub, shl, sha;
  logic              unused_bits;

  assign opx  = {{(DW-NIB_W){1'b0}}, opnd_pack_i[2*NIB_W-1:NIB_W]};
  assign opy  = {{(DW-NIB_W){1'b0}}, opnd_pack_i[NIB_W-1:0]};
  assign code = sel_bus_i[CODE_W-1:0];

  assign do_sub = (code == OP_SUB);
  assign shl    = (code == OP_SLL);
  assign sha    = (code == OP_SRA);

  nalu_addsub #(.DW(DW)) u_addsub (
    .a_i(opx), .b_i(opy), .sub_i(do_sub), .sum_o(sum)
  );

  nalu_compare #(.DW(DW)) u_cmp (
    .a_i(opx), .b_i(opy), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  nalu_shifter #(.DW(DW), .SW(SW)) u_shift (
    .data_i(opx), .amt_i(opy[SW-1:0]), .left_i(shl), .arith_i(sha),
    .res_o(shifted)
  );

  always_comb begin
    case (code)
      OP_SLL, OP_SRL, OP_SRA: full_res = shifted;
      OP_ADD, OP_SUB:         full_res = sum;
      OP_AND:                 full_res = opx & opy;
      OP_OR:                  full_res = opx | opy;
      OP_XOR:                 full_res = opx ^ opy;
      OP_SLT:                 full_res = {{(DW-1){1'b0}}, lt_s};
      OP_SLTU:                full_res = {{(DW-1){1'b0}}, lt_u};
      default:                full_res = '0;
    endcase
  end

  assign result_o    = full_res[PIN_W-1:0];
  assign aux_out_o   = '0;
  assign aux_oe_o    = '0;
  assign unused_bits = ^{full_res[DW-1:PIN_W], sel_bus_i[PIN_W-1:CODE_W],
                         opy[DW-1:SW]};
endmodule

// File: rtl/nalu_checker.sv
module nalu_checker #(
  parameter int unsigned PIN_W = 8,
  parameter int unsigned NIB_W = 4
) (
  input logic [PIN_W-1:0] opnd_pack_i,
  input logic [PIN_W-1:0] sel_bus_i,
  input logic [PIN_W-1:0] result_o,
  input logic [PIN_W-1:0] aux_out_o,
  input logic [PIN_W-1:0] aux_oe_o
);
  logic [PIN_W-1:0] xw, yw;
  logic [3:0]       c;
  logic             unused_chk;

  assign xw = {{(PIN_W-NIB_W){1'b0}}, opnd_pack_i[2*NIB_W-1:NIB_W]};
  assign yw = {{(PIN_W-NIB_W){1'b0}}, opnd_pack_i[NIB_W-1:0]};
  assign c  = sel_bus_i[3:0];
  assign unused_chk = ^sel_bus_i[PIN_W-1:4];

  always_comb begin
    assert_pins_quiet_R11: assert (aux_oe_o == '0 && aux_out_o == '0)
      else $error("bidirectional group driven");
    if (c == 4'h3 || c == 4'h5 || c >= 4'hC)
      assert_spare_zero_R10: assert (result_o == '0)
        else $error("spare code result nonzero");
    if (c == 4'h4)
      assert_add_sum_R4: assert (result_o == PIN_W'(xw + yw))
        else $error("add mismatch");
    if (c == 4'h6)
      assert_sub_wrap_R5: assert (result_o == PIN_W'(xw - yw))
        else $error("sub mismatch");
    if (c == 4'hA || c == 4'hB)
      assert_cmp_flag_R7: assert (result_o == {{(PIN_W-1){1'b0}}, (xw < yw)})
        else $error("compare mismatch");
    if (c == 4'h1 || c == 4'h2)
      assert_shr_fill_R9: assert (result_o == (xw >> yw))
        else $error("right shift mismatch");
  end
endmodule

bind nalu_top nalu_checker #(.PIN_W(PIN_W), .NIB_W(NIB_W)) u_nalu_chk (
  .opnd_pack_i(opnd_pack_i),
  .sel_bus_i(sel_bus_i),
  .result_o(result_o),
  .aux_out_o(aux_out_o),
  .aux_oe_o(aux_oe_o)
);

// File: tb/nalu_top_bench.sv
module nalu_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opnd, sel;
  logic [7:0] res, aux_out, aux_oe;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nalu_top u_nalu_top (
    .opnd_pack_i(opnd), .sel_bus_i(sel), .result_o(res),
    .aux_out_o(aux_out), .aux_oe_o(aux_oe)
  );

  function automatic logic [31:0] ref_alu(int code, int xa, int yb);
    logic [31:0] x, y;
    x = 32'(xa); y = 32'(yb);
    case (code)
      0:  return x << y[4:0];
      1:  return x >> y[4:0];
      2:  return $unsigned($signed(x) >>> y[4:0]);
      4:  return x + y;
      6:  return x - y;
      7:  return x & y;
      8:  return x | y;
      9:  return x ^ y;
      10: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      11: return (x < y) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int code);
    case (code)
      0: return "R8";
      1, 2: return "R9";
      4: return "R4";
      6: return "R5";
      7, 8, 9: return "R6";
      10, 11: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h (opnd=0x%02h sel=0x%02h)",
               tag, got, exp, opnd, sel);
    end
  endtask

  task automatic fixed_case(logic [7:0] p, logic [3:0] c, logic [7:0] exp);
    @(posedge clk); #1;
    opnd = p; sel = {4'h0, c};
    @(negedge clk);
    check8("R12", res, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opnd = 8'h00; sel = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands, code 0 (SLL) gives zero (R8, R11)
    check8("R8", res, 8'h00);
    check8("R11", aux_oe, 8'h00);
    rst_n = 1'b1;

    // R1: change inputs mid-cycle and observe without a clock edge
    @(negedge clk);
    opnd = 8'h53; sel = 8'h04;
    #1 check8("R1", res, 8'h08);
    opnd = 8'h35; sel = 8'h06;
    #1 check8("R1", res, 8'hFE);

    // R12 fixed cases and the R5 wrap example
    fixed_case(8'h53, 4'h4, 8'h08);
    fixed_case(8'hA3, 4'h6, 8'h07);
    fixed_case(8'hF5, 4'h7, 8'h05);
    fixed_case(8'hA5, 4'h8, 8'h0F);
    fixed_case(8'hFF, 4'h9, 8'h00);
    fixed_case(8'h35, 4'hA, 8'h01);
    @(posedge clk); #1; opnd = 8'h35; sel = 8'h06;
    @(negedge clk); check8("R5", res, 8'hFE);

    // Full sweep; upper select nibble varies (R3), nibble order checked (R2)
    for (int code = 0; code < 16; code++) begin
      for (int p = 0; p < 256; p++) begin
        logic [31:0] exp;
        @(posedge clk); #1;
        opnd = 8'(p);
        sel  = {4'(p ^ (p >> 4) ^ code), 4'(code)};
        exp  = ref_alu(code, p >> 4, p & 15);
        @(negedge clk);
        check8(tag_of(code), res, exp[7:0]);
        if (((p ^ code) & 8'h3F) == 0) begin
          check8("R11", aux_out, 8'h00);
          check8("R11", aux_oe, 8'h00);
        end
      end
    end

    // R2/R3 spot checks: swapped nibbles differ for SUB; upper select ignored
    @(posedge clk); #1; opnd = 8'h91; sel = 8'hF6;
    @(negedge clk); check8("R3", res, 8'h08);
    @(posedge clk); #1; opnd = 8'h19; sel = 8'h06;
    @(negedge clk); check8("R2", res, 8'hF8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule